// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block drives one transmit channel. It walks a chain of four-word data descriptors kept in system memory, reads the buffer that each one names, and hands the bytes to a client over a byte-wide valid/ready stream. When a buffer is drained, the block optionally raises an interrupt-set pulse and marks the packet end on the stream. It then writes the descriptor back and moves on through the next pointer. At a descriptor whose end-of-list bit is set, the engine latches a list-end flag, marks the owning context descriptor as disabled, and goes quiet.

Software first points the engine at a context descriptor, which supplies the descriptor pointer and the buffer position. Software then pulses start. To extend a finished list, software links a new descriptor behind the last one, clears that descriptor's end-of-list bit, and pulses continue. The engine then re-reads the last descriptor, sees the cleared bit, and carries on from its next pointer. All memory traffic goes through one word-wide port with a request/acknowledge handshake.

Top module: `txdesc_dma`

## Requirements
- R1: A data descriptor at byte address P is four words: next pointer at P+0, buffer start at P+4, control word at P+8, and buffer end (one past the last byte) at P+12. A descriptor fetch reads all four words, in that address order.
- R2: Bytes leave in ascending address order, from the current position up to the buffer end minus one. The byte at address A is bits [8*(A mod 4)+7 : 8*(A mod 4)] of the word at A rounded down to a multiple of 4. A byte counts as sent only in a cycle where both tx_valid_o and tx_ready_i are high, and data and last stay stable while the client stalls.
- R3: If control bit 3 is set, tx_last_o is high on the final byte of the buffer, and it is low on all other bytes. A descriptor whose position already equals its end sends no bytes.
- R4: When a descriptor's buffer is drained and its control bit 4 is set, irq_set_o is high for exactly one cycle.
- R5: After a buffer is drained, the four descriptor words are written back, unchanged, to the addresses they were read from.
- R6: When the drained descriptor has control bit 0 clear, the engine fetches the descriptor at its next pointer and continues from that descriptor's buffer start.
- R7: When the drained descriptor has control bit 0 set, eol_o goes high. The engine then reads the context word at context address + 4, writes it back with bit 15 set, and drops busy_o.
- R8: A pulse on ld_ctx_i reads the word at ctx_addr_i + 24 as the descriptor pointer and the word at ctx_addr_i + 28 as the buffer position. A later start transfers from that position, not from the buffer start.
- R9: start_i takes effect only when en_i is high and stop_i is low. An accepted start clears eol_o and puts the channel in the running state.
- R10: cont_i takes effect only when en_i is high, stop_i is low, the channel is running and the held descriptor has control bit 0 set. The engine then re-reads that descriptor. If the re-read shows bit 0 clear while eol_o is set, the engine follows the next pointer as in R6. Otherwise it returns to idle without moving data or writing memory.
- R11: After CHUNK_BYTES bytes have been sent since the last descriptor fetch, and before any further data is read, the engine fetches the current descriptor again. The position is kept.
- R12: busy_o is high whenever a memory or stream operation is in progress, and ld_ctx_i, start_i and cont_i are ignored while it is high. When strobes coincide in idle, ld_ctx_i wins over start_i, and start_i wins over cont_i.
- R13: mem_req_o stays high with a stable address, direction and write data until mem_ack_i is seen. Each acknowledged beat moves one 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable level |
| stop_i | input | 1 | Channel stop level |
| ctx_addr_i | input | 32 | Context descriptor byte address |
| ld_ctx_i | input | 1 | Strobe: load pointer and position from context |
| start_i | input | 1 | Strobe: start the descriptor walk |
| cont_i | input | 1 | Strobe: continue after list end |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the beat |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Stream end of packet |
| tx_ready_i | input | 1 | Client ready |
| irq_set_o | output | 1 | One-cycle interrupt-set pulse |
| busy_o | output | 1 | Engine active |
| eol_o | output | 1 | Latched list-end flag |

## Verification
The assertions rely on three things. The memory answers every request eventually and never acknowledges when nothing is requested. Descriptors are word aligned and each buffer position lies at or below its end address. Strobes are single-cycle pulses. The stimulus places every descriptor and context on a word boundary inside a modelled 2 KiB memory, with each buffer end at or above its start position. Acknowledges come only while a request is pending, on a pseudo-random pattern, and ready comes on an independent pseudo-random pattern, so both stall paths are exercised.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W = 32;

  // descriptor word slots
  localparam int W_NEXT = 0;
  localparam int W_BUF  = 1;
  localparam int W_CTL  = 2;
  localparam int W_END  = 3;

  // control word bit positions
  localparam int CB_EOL = 0;
  localparam int CB_EOP = 3;
  localparam int CB_IRQ = 4;
  localparam int CB_DIS = 15;

  // context word offsets (bytes)
  localparam logic [WORD_W-1:0] CTX_CTL_OFS = 32'd4;
  localparam logic [WORD_W-1:0] CTX_PTR_OFS = 32'd24;
  localparam logic [WORD_W-1:0] CTX_POS_OFS = 32'd28;

  typedef enum logic [3:0] {
    S_IDLE, S_CTX, S_FETCH, S_DECIDE, S_XFER,
    S_RDW, S_STREAM, S_WB, S_CRD, S_CWR
  } eng_st_t;

  typedef enum logic [1:0] { K_KEEP, K_BUF, K_CONT } fetch_kind_t;

  typedef enum logic [1:0] { CH_RST, CH_STOP, CH_RUN } chan_st_t;

  function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w,
                                           input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                  input logic [1:0] idx);
    return base + {28'd0, idx, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] word_base(input logic [WORD_W-1:0] a);
    return {a[WORD_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/txd_lane.sv
module txd_lane
  import txd_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048,
  localparam int CNT_W = $clog2(CHUNK_BYTES + 1)
) (
  input  logic [WORD_W-1:0] pos_i,
  input  logic [WORD_W-1:0] end_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [7:0]        byte_o,
  output logic              final_o,
  output logic              word_end_o,
  output logic              chunk_end_o
);
  logic [CNT_W:0] cnt_nx;

  always_comb begin
    byte_o      = lane_byte(word_i, pos_i[1:0]);
    final_o     = (pos_i + 32'd1) == end_i;
    word_end_o  = pos_i[1:0] == 2'b11;
    cnt_nx      = {1'b0, cnt_i} + {{CNT_W{1'b0}}, 1'b1};
    chunk_end_o = cnt_nx == (CNT_W+1)'(CHUNK_BYTES);
  end
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048,
  localparam int CNT_W = $clog2(CHUNK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] ctx_addr_i,
  input  logic              ld_ctx_i,
  input  logic              start_i,
  input  logic              cont_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              tx_ready_i,
  input  logic              final_i,
  input  logic              word_end_i,
  input  logic              chunk_end_i,
  output logic [WORD_W-1:0] pos_o,
  output logic [WORD_W-1:0] end_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              stream_o,
  output logic              eop_flag_o,
  output logic              desc_done_o,
  output logic              irq_set_o,
  output logic              busy_o,
  output logic              eol_o
);
  eng_st_t          st_q;
  fetch_kind_t      kind_q;
  chan_st_t         ch_q;
  logic [1:0]       widx_q;
  logic [WORD_W-1:0] ptr_q, pos_q, ctx_q, word_q, ctxw_q;
  logic [WORD_W-1:0] dw_q [4];
  logic [CNT_W-1:0] cnt_q;
  logic             eol_q, irq_q;
  logic             can_go, start_ok, cont_ok, ld_ok, beat, at_end, chunk_full;

  assign can_go     = en_i && !stop_i;
  assign ld_ok      = (st_q == S_IDLE) && ld_ctx_i;
  assign start_ok   = (st_q == S_IDLE) && !ld_ctx_i && start_i && can_go;
  assign cont_ok    = (st_q == S_IDLE) && !ld_ctx_i && !start_i && cont_i && can_go
                      && (ch_q == CH_RUN) && dw_q[W_CTL][CB_EOL];
  assign beat       = mem_req_o && mem_ack_i;
  assign at_end     = pos_q == dw_q[W_END];
  assign chunk_full = cnt_q == CNT_W'(CHUNK_BYTES);

  assign pos_o       = pos_q;
  assign end_o       = dw_q[W_END];
  assign word_o      = word_q;
  assign cnt_o       = cnt_q;
  assign stream_o    = st_q == S_STREAM;
  assign eop_flag_o  = dw_q[W_CTL][CB_EOP];
  assign desc_done_o = (st_q == S_XFER) && at_end;
  assign irq_set_o   = irq_q;
  assign busy_o      = st_q != S_IDLE;
  assign eol_o       = eol_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st_q)
      S_CTX: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ctx_q + (widx_q[0] ? CTX_POS_OFS : CTX_PTR_OFS);
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = slot_addr(ptr_q, widx_q);
      end
      S_RDW: begin
        mem_req_o  = 1'b1;
        mem_addr_o = word_base(pos_q);
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_addr(ptr_q, widx_q);
        mem_wdata_o = dw_q[widx_q];
      end
      S_CRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ctx_q + CTX_CTL_OFS;
      end
      S_CWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q + CTX_CTL_OFS;
        mem_wdata_o = ctxw_q | (32'd1 << CB_DIS);
      end
      default: ;
    endcase
  end

  // channel state follows the enable/stop levels, running only via start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ch_q <= CH_RST;
    else if (!en_i)      ch_q <= CH_RST;
    else if (stop_i)     ch_q <= CH_STOP;
    else if (start_ok)   ch_q <= CH_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_KEEP;
      widx_q <= '0;
      ptr_q  <= '0;
      pos_q  <= '0;
      ctx_q  <= '0;
      word_q <= '0;
      ctxw_q <= '0;
      cnt_q  <= '0;
      eol_q  <= 1'b0;
      irq_q  <= 1'b0;
      for (int i = 0; i < 4; i++) dw_q[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          widx_q <= '0;
          if (ld_ok) begin
            ctx_q <= ctx_addr_i;
            st_q  <= S_CTX;
          end else if (start_ok) begin
            eol_q  <= 1'b0;
            kind_q <= K_KEEP;
            st_q   <= S_FETCH;
          end else if (cont_ok) begin
            kind_q <= K_CONT;
            st_q   <= S_FETCH;
          end
        end
        S_CTX: if (beat) begin
          if (!widx_q[0]) begin
            ptr_q  <= mem_rdata_i;
            widx_q <= 2'd1;
          end else begin
            pos_q <= mem_rdata_i;
            st_q  <= S_IDLE;
          end
        end
        S_FETCH: if (beat) begin
          dw_q[widx_q] <= mem_rdata_i;
          widx_q       <= widx_q + 2'd1;
          if (widx_q == 2'd3) st_q <= S_DECIDE;
        end
        S_DECIDE: begin
          case (kind_q)
            K_KEEP: begin
              cnt_q <= '0;
              st_q  <= S_XFER;
            end
            K_BUF: begin
              pos_q <= dw_q[W_BUF];
              cnt_q <= '0;
              st_q  <= S_XFER;
            end
            default: begin
              if (!dw_q[W_CTL][CB_EOL] && eol_q) begin
                ptr_q  <= dw_q[W_NEXT];
                eol_q  <= 1'b0;
                kind_q <= K_BUF;
                widx_q <= '0;
                st_q   <= S_FETCH;
              end else begin
                st_q <= S_IDLE;
              end
            end
          endcase
        end
        S_XFER: begin
          widx_q <= '0;
          if (at_end) begin
            irq_q <= dw_q[W_CTL][CB_IRQ];
            st_q  <= S_WB;
          end else if (chunk_full) begin
            kind_q <= K_KEEP;
            st_q   <= S_FETCH;
          end else begin
            st_q <= S_RDW;
          end
        end
        S_RDW: if (beat) begin
          word_q <= mem_rdata_i;
          st_q   <= S_STREAM;
        end
        S_STREAM: if (tx_ready_i) begin
          pos_q <= pos_q + 32'd1;
          cnt_q <= cnt_q + CNT_W'(1);
          if (final_i || word_end_i || chunk_end_i) st_q <= S_XFER;
        end
        S_WB: if (beat) begin
          widx_q <= widx_q + 2'd1;
          if (widx_q == 2'd3) begin
            if (dw_q[W_CTL][CB_EOL]) begin
              eol_q <= 1'b1;
              st_q  <= S_CRD;
            end else begin
              ptr_q  <= dw_q[W_NEXT];
              kind_q <= K_BUF;
              widx_q <= '0;
              st_q   <= S_FETCH;
            end
          end
        end
        S_CRD: if (beat) begin
          ctxw_q <= mem_rdata_i;
          st_q   <= S_CWR;
        end
        S_CWR: if (beat) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048,
  localparam int CNT_W = $clog2(CHUNK_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        stop_i,
  input  logic [31:0] ctx_addr_i,
  input  logic        ld_ctx_i,
  input  logic        start_i,
  input  logic        cont_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        irq_set_o,
  output logic        busy_o,
  output logic        eol_o
);
  logic [WORD_W-1:0] pos_w, end_w, word_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              final_w, word_end_w, chunk_end_w;
  logic              stream_w, eop_flag_w, desc_done_w;

  txd_lane #(.CHUNK_BYTES(CHUNK_BYTES)) u_lane (
    .pos_i      (pos_w),
    .end_i      (end_w),
    .word_i     (word_w),
    .cnt_i      (cnt_w),
    .byte_o     (tx_data_o),
    .final_o    (final_w),
    .word_end_o (word_end_w),
    .chunk_end_o(chunk_end_w)
  );

  txd_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .stop_i     (stop_i),
    .ctx_addr_i (ctx_addr_i),
    .ld_ctx_i   (ld_ctx_i),
    .start_i    (start_i),
    .cont_i     (cont_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .tx_ready_i (tx_ready_i),
    .final_i    (final_w),
    .word_end_i (word_end_w),
    .chunk_end_i(chunk_end_w),
    .pos_o      (pos_w),
    .end_o      (end_w),
    .word_o     (word_w),
    .cnt_o      (cnt_w),
    .stream_o   (stream_w),
    .eop_flag_o (eop_flag_w),
    .desc_done_o(desc_done_w),
    .irq_set_o  (irq_set_o),
    .busy_o     (busy_o),
    .eol_o      (eol_o)
  );

  assign tx_valid_o = stream_w;
  assign tx_last_o  = stream_w && final_w && eop_flag_w;
endmodule

// File: rtl/txd_dma_chk.sv
module txd_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_last_o,
  input logic        tx_ready_i,
  input logic        irq_set_o,
  input logic        busy_o,
  input logic        eol_o,
  input logic        desc_done_w
);
  // R13: a pending request holds until acknowledged
  p_memreq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R2: a stalled byte stays put
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R3: packet end only marks a valid byte
  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o);

  // R4: interrupt set is a single-cycle pulse that follows a drained descriptor
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |=> !irq_set_o);
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> $past(desc_done_w));

  // R12: no traffic while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !tx_valid_o);

  // R7: list end is latched while the context update is still pending
  p_eol_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eol_o) |-> busy_o && !tx_valid_o);
endmodule

bind txdesc_dma txd_dma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_last_o  (tx_last_o),
  .tx_ready_i (tx_ready_i),
  .irq_set_o  (irq_set_o),
  .busy_o     (busy_o),
  .eol_o      (eol_o),
  .desc_done_w(desc_done_w)
);

// File: tb/txdesc_dma_bench.sv
`timescale 1ns/1ps
module txdesc_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, stop_i = 1'b0;
  logic [31:0] ctx_addr_i = '0;
  logic        ld_ctx_i = 1'b0, start_i = 1'b0, cont_i = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_last_o, tx_ready_i = 1'b0;
  logic        irq_set_o, busy_o, eol_o;

  always #10 clk = ~clk;

  txdesc_dma #(.CHUNK_BYTES(8)) u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .stop_i(stop_i),
    .ctx_addr_i(ctx_addr_i), .ld_ctx_i(ld_ctx_i), .start_i(start_i), .cont_i(cont_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o),
    .tx_ready_i(tx_ready_i), .irq_set_o(irq_set_o), .busy_o(busy_o), .eol_o(eol_o)
  );

  // behavioural memory and reference queues
  logic [31:0] mem [0:511];
  logic [8:0]  exp_b [$];
  logic [63:0] exp_w [$];
  int          rd_cnt [int];
  int          checks = 0, errors = 0, irq_seen = 0, beats = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign mem_rdata_i = mem[mem_addr_o[10:2]];

  function automatic logic [7:0] bval(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic int rds(input int a);
    return rd_cnt.exists(a) ? rd_cnt[a] : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // responder and monitor, all away from the rising edge
  always @(negedge clk) begin
    lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = lfsr[0] | lfsr[3];
    mem_ack_i  = mem_req_o && (lfsr[5] | lfsr[9]);
    #1;
    if (rst_n && mem_req_o && mem_ack_i) begin
      beats++;
      if (mem_we_o) begin
        if (exp_w.size() == 0)
          chk(1'b0, "R5 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
        else begin
          logic [63:0] e;
          e = exp_w.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R5/R7 write", {mem_addr_o, mem_wdata_o}, e);
        end
        mem[mem_addr_o[10:2]] = mem_wdata_o;
      end else begin
        rd_cnt[int'(mem_addr_o)] = rds(int'(mem_addr_o)) + 1;
      end
    end
    if (rst_n && tx_valid_o && tx_ready_i) begin
      if (exp_b.size() == 0)
        chk(1'b0, "R2 unexpected byte", {tx_last_o, tx_data_o}, 0);
      else begin
        logic [8:0] e;
        e = exp_b.pop_front();
        chk({tx_last_o, tx_data_o} == e, "R2/R3 byte", {tx_last_o, tx_data_o}, e);
      end
    end
    if (rst_n && irq_set_o) irq_seen++;
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic put_word(input int a, input logic [31:0] v);
    mem[a >> 2] = v;
  endtask

  task automatic put_desc(input int p, input int nx, input int bf, input int ctl, input int en);
    put_word(p, nx); put_word(p + 4, bf); put_word(p + 8, ctl); put_word(p + 12, en);
  endtask

  task automatic exp_desc_wb(input int p);
    for (int k = 0; k < 4; k++) exp_w.push_back({32'(p + 4*k), mem[(p >> 2) + k]});
  endtask

  task automatic exp_ctx_dis(input int c);
    exp_w.push_back({32'(c + 4), mem[(c + 4) >> 2] | 32'h8000});
  endtask

  task automatic exp_bytes(input int from, input int to, input bit eop);
    for (int a = from; a < to; a++) exp_b.push_back({eop && (a == to - 1), bval(a)});
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    ld_ctx_i = (which == 0); start_i = (which == 1); cont_i = (which == 2);
    @(negedge clk);
    ld_ctx_i = 1'b0; start_i = 1'b0; cont_i = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    #2;
  endtask

  initial begin
    int irq0, b0;
    for (int w = 0; w < 512; w++)
      mem[w] = {bval(4*w + 3), bval(4*w + 2), bval(4*w + 1), bval(4*w)};
    // context at 0x000, descriptors at 0x040, 0x050, 0x060
    put_word(32'h004, 32'h1234_0000);
    put_word(32'h018, 32'h040);
    put_word(32'h01C, 32'h103);
    put_desc(32'h040, 32'h050, 32'h101, 32'h18, 32'h10B);
    put_desc(32'h050, 32'h000, 32'h201, 32'h09, 32'h215);
    // second context at 0x020 pointing to 0x070
    put_word(32'h024, 32'h0);
    put_word(32'h038, 32'h070);
    put_word(32'h03C, 32'h400);
    put_desc(32'h070, 32'h000, 32'h400, 32'h19, 32'h406);

    repeat (5) @(negedge clk);
    #2;
    chk(!busy_o && !mem_req_o && !tx_valid_o && !irq_set_o && !eol_o,
        "reset R12", {busy_o, mem_req_o, tx_valid_o, irq_set_o, eol_o}, 0);
    rst_n = 1'b1;
    en_i  = 1'b1;

    // T1: context load, start mid-buffer, two descriptors, chunked second one
    exp_bytes(32'h103, 32'h10B, 1'b1);      // R8 position from context
    exp_desc_wb(32'h040);                    // R5
    exp_bytes(32'h201, 32'h215, 1'b1);       // R6 new buffer start
    exp_desc_wb(32'h050);
    exp_ctx_dis(32'h000);                    // R7
    ctx_addr_i = 32'h000;
    strobe(0);
    wait_idle();
    strobe(1);
    wait_idle();
    chk(exp_b.size() == 0, "R2 all bytes sent", exp_b.size(), 0);
    chk(exp_w.size() == 0, "R5 all write-backs", exp_w.size(), 0);
    chk(irq_seen == 1, "R4 irq count", irq_seen, 1);
    chk(eol_o == 1'b1 && !busy_o, "R7 list end", {eol_o, busy_o}, 2'b10);
    chk(rds(32'h040) == 1 && rds(32'h04C) == 1, "R1 first descriptor read once",
        rds(32'h04C), 1);
    chk(rds(32'h050) == 3, "R11 refetch on chunk limit", rds(32'h050), 3);
    chk(rds(32'h018) == 1 && rds(32'h01C) == 1, "R8 context words read",
        rds(32'h01C), 1);

    // T2: continue while last descriptor still ends the list
    b0 = beats;
    strobe(2);
    wait_idle();
    chk(rds(32'h050) == 4 && beats - b0 == 4, "R10 re-read only", beats - b0, 4);
    chk(eol_o == 1'b1, "R10 list end kept", eol_o, 1);

    // T3: append a zero-length descriptor and continue
    put_desc(32'h060, 32'h000, 32'h300, 32'h11, 32'h300);
    put_word(32'h050, 32'h060);
    put_word(32'h058, 32'h08);
    exp_desc_wb(32'h060);
    exp_w.push_back({32'h004, 32'h1234_8000});
    strobe(2);
    wait_idle();
    chk(rds(32'h060) == 1, "R10 followed next pointer", rds(32'h060), 1);
    chk(exp_w.size() == 0 && exp_b.size() == 0, "R3 zero-length sends no bytes",
        exp_w.size() + exp_b.size(), 0);
    chk(irq_seen == 2, "R4 irq on zero-length", irq_seen, 2);
    chk(eol_o == 1'b1, "R7 list end again", eol_o, 1);

    // T4: new context, strobes during activity are ignored
    exp_bytes(32'h400, 32'h406, 1'b1);
    exp_desc_wb(32'h070);
    exp_ctx_dis(32'h020);
    ctx_addr_i = 32'h020;
    strobe(0);
    wait_idle();
    ctx_addr_i = 32'h000;
    strobe(1);
    repeat (2) @(negedge clk);
    #2;
    chk(eol_o == 1'b0 && busy_o, "R9 start clears list end", {eol_o, busy_o}, 2'b01);
    strobe(1);
    strobe(0);
    strobe(2);
    wait_idle();
    chk(exp_b.size() == 0 && exp_w.size() == 0, "R12 busy strobes ignored",
        exp_b.size() + exp_w.size(), 0);
    chk(rds(32'h070) == 1 && rds(32'h018) == 1, "R12 no extra fetch", rds(32'h070), 1);
    chk(irq_seen == 3, "R4 irq count final", irq_seen, 3);

    // T5: start with channel disabled
    en_i = 1'b0;
    b0 = beats;
    irq0 = irq_seen;
    strobe(1);
    repeat (20) @(negedge clk);
    #2;
    chk(beats == b0 && !busy_o, "R9 start ignored when disabled", beats - b0, 0);

    // T6: continue while stopped
    en_i   = 1'b1;
    stop_i = 1'b1;
    strobe(2);
    repeat (20) @(negedge clk);
    #2;
    chk(beats == b0 && !busy_o && irq_seen == irq0, "R10 continue ignored when stopped",
        beats - b0, 0);
    stop_i = 1'b0;
    summary();
  end
endmodule